// File: doc/BRIEF.md
# Periodic Sync Pulse Scheduler

This block sits in the transmit path of a one-way serial link. The link has no return channel, so the transmitter cannot learn whether the far receiver is locked. At a fixed, programmable interval the block raises a sync pulse. While the pulse is high, the transmitter sends only the fill frame that the receiver uses to acquire frame lock. A receiver that has lost lock therefore regains it within one interval at most.

For the whole pulse, plus one guard cycle on each side, a data-ready output tells the user data source that the link is busy. No user word is accepted in that window.

Pulse width and interval are counts of the block clock, and software can change both at runtime. A two-bit rate band selector sets a minimum width. Band 0 is the fastest rate, and each slower band doubles the minimum. A width below the minimum is raised to it. A separate output is held at the constant level that selects the lock-capable fill frame.

Top module: `sync_pulse_sched`

## Requirements
- R1: In every period, `sync_pulse` is high for exactly W_eff consecutive cycles. Count the cycles of a period from 0, with cycle 0 being the first cycle after reset or after a wrap. The pulse covers cycles 1 through W_eff.
- R2: `data_ready` is low from cycle 0 through cycle W_eff+1. This is one cycle before the pulse starts to one cycle after it ends. `data_ready` is high for the rest of the period.
- R3: Consecutive rising edges of `sync_pulse` are exactly P_eff cycles apart.
- R4: The band minimum is BASE_MIN shifted left by `band_sel`, with band 0 being the fastest. W_eff is the larger of `cfg_width` and that minimum.
- R5: P_eff is the larger of `cfg_period` and W_eff+3, so each period has at least one cycle with `data_ready` high.
- R6: A change to `cfg_width`, `cfg_period` or `band_sel` made part-way through a period has no effect on that period. It takes effect from cycle 0 of the next period.
- R7: While `rst` is high at a clock edge, both `sync_pulse` and `data_ready` are low. The first cycle after reset is cycle 0 of a new period, so the pulse starts in the cycle after that.
- R8: `fill_sel` is constantly high, which selects the fill frame used for lock.
- R9: `sync_pulse` and `data_ready` are never high in the same cycle.
- R10: W_eff is capped at 2^WIDTH-4, which keeps P_eff representable in WIDTH bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; all counts are in its cycles |
| rst | input | 1 | Synchronous active-high reset |
| cfg_width | input | WIDTH | Requested pulse width in cycles |
| cfg_period | input | WIDTH | Requested interval between pulse starts in cycles |
| band_sel | input | 2 | Rate band, 0 fastest, 3 slowest |
| sync_pulse | output | 1 | High while the transmitter must send the lock fill frame |
| data_ready | output | 1 | High when the user source may present a word |
| fill_sel | output | 1 | Constant fill frame select, always high |

## Verification
The bench builds the block with WIDTH of 12 and BASE_MIN of 4. With these values the band minimums are 4, 8, 16 and 32 cycles. Every floor clamp, the period clamp and the exact boundary P = W+3 can then be reached in a few dozen cycles. A 12-bit counter also brings the upper width cap of 4092 cycles, with its 4095-cycle period, within a run of a few thousand cycles. The same short periods let the bench place a configuration change inside a running period and watch for its effect at the following wrap.

// File: rtl/sync_sched_pkg.sv
package sync_sched_pkg;

    // Rate bands: index 0 is the fastest link rate, each step down doubles
    // the minimum sync width.
    typedef enum logic [1:0] {
        BAND_TOP  = 2'd0,
        BAND_HIGH = 2'd1,
        BAND_MID  = 2'd2,
        BAND_LOW  = 2'd3
    } band_e;

    // Busy cycle ahead of the pulse and after it.
    localparam int unsigned GUARD_LEAD = 1;
    localparam int unsigned GUARD_TAIL = 1;
    // Period must exceed width by this much so one ready cycle remains.
    localparam int unsigned PERIOD_SLACK = GUARD_LEAD + GUARD_TAIL + 1;

    // Largest width that still leaves the slack inside a W-bit period.
    function automatic int unsigned width_cap(input int unsigned w_bits);
        return (2 ** w_bits) - 1 - PERIOD_SLACK;
    endfunction

endpackage

// File: rtl/sync_sched_cfg.sv
module sync_sched_cfg
    import sync_sched_pkg::*;
#(
    parameter int unsigned WIDTH    = 16,
    parameter int unsigned BASE_MIN = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [WIDTH-1:0] cfg_width,
    input  logic [WIDTH-1:0] cfg_period,
    input  band_e            band,
    output logic [WIDTH-1:0] w_act,
    output logic [WIDTH-1:0] p_act
);
    localparam int unsigned XW    = WIDTH + 1;
    localparam logic [XW-1:0] CAP  = XW'(width_cap(WIDTH));
    localparam logic [XW-1:0] BASE = XW'(BASE_MIN);
    localparam logic [XW-1:0] SLK  = XW'(PERIOD_SLACK);

    logic [XW-1:0] floor_v, w_x, p_x;

    always_comb begin
        floor_v = BASE << band;
        w_x     = {1'b0, cfg_width};
        if (w_x < floor_v) w_x = floor_v;
        if (w_x > CAP)     w_x = CAP;
        p_x     = {1'b0, cfg_period};
        if (p_x < w_x + SLK) p_x = w_x + SLK;
    end

    always_ff @(posedge clk) begin
        if (rst || load) begin
            w_act <= w_x[WIDTH-1:0];
            p_act <= p_x[WIDTH-1:0];
        end
    end

    // R5: latched period always leaves room for guards and one ready cycle
    assert_period_room_R5: assert property (@(posedge clk) disable iff (rst)
        ({1'b0, p_act} >= {1'b0, w_act} + SLK));

    // R10: latched width never exceeds the cap
    assert_width_cap_R10: assert property (@(posedge clk) disable iff (rst)
        ({1'b0, w_act} <= CAP));

    // R6: settings hold for the whole period
    assert_hold_mid_period_R6: assert property (@(posedge clk) disable iff (rst)
        !load |=> ($stable(w_act) && $stable(p_act)));
endmodule

// File: rtl/sync_sched_timer.sv
module sync_sched_timer #(
    parameter int unsigned WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] p_act,
    output logic [WIDTH-1:0] cnt,
    output logic             wrap
);
    assign wrap = (cnt == p_act - WIDTH'(1));

    always_ff @(posedge clk) begin
        if (rst || wrap) cnt <= '0;
        else             cnt <= cnt + WIDTH'(1);
    end

    // R3: the count returns to zero only from the last cycle of a period
    assert_wrap_at_end_R3: assert property (@(posedge clk) disable iff (rst)
        (cnt == '0 && !$past(rst)) |-> ($past(cnt) == $past(p_act) - WIDTH'(1)));
endmodule

// File: rtl/sync_sched_decode.sv
module sync_sched_decode
    import sync_sched_pkg::*;
#(
    parameter int unsigned WIDTH = 16
) (
    input  logic [WIDTH-1:0] cnt,
    input  logic [WIDTH-1:0] w_act,
    output logic             pulse,
    output logic             ready
);
    localparam int unsigned XW = WIDTH + 1;
    logic [XW-1:0] c_x, w_x;

    always_comb begin
        c_x   = {1'b0, cnt};
        w_x   = {1'b0, w_act};
        pulse = (c_x >= XW'(GUARD_LEAD)) && (c_x <= w_x);
        ready = (c_x > w_x + XW'(GUARD_TAIL));
    end
endmodule

// File: rtl/sync_pulse_sched.sv
module sync_pulse_sched
    import sync_sched_pkg::*;
#(
    parameter int unsigned WIDTH    = 16,
    parameter int unsigned BASE_MIN = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] cfg_width,
    input  logic [WIDTH-1:0] cfg_period,
    input  logic [1:0]       band_sel,
    output logic             sync_pulse,
    output logic             data_ready,
    output logic             fill_sel
);
    logic [WIDTH-1:0] w_act, p_act, cnt;
    logic             wrap;

    sync_sched_cfg #(.WIDTH(WIDTH), .BASE_MIN(BASE_MIN)) u_cfg (
        .clk(clk), .rst(rst), .load(wrap),
        .cfg_width(cfg_width), .cfg_period(cfg_period),
        .band(band_e'(band_sel)),
        .w_act(w_act), .p_act(p_act)
    );

    sync_sched_timer #(.WIDTH(WIDTH)) u_timer (
        .clk(clk), .rst(rst), .p_act(p_act), .cnt(cnt), .wrap(wrap)
    );

    sync_sched_decode #(.WIDTH(WIDTH)) u_dec (
        .cnt(cnt), .w_act(w_act), .pulse(sync_pulse), .ready(data_ready)
    );

    assign fill_sel = 1'b1;

    // R9: no user word can be offered while the fill frame is forced
    assert_busy_during_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        sync_pulse |-> !data_ready);

    // R2: ready was already low in the cycle before the pulse rose
    assert_lead_guard_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(sync_pulse) |-> !$past(data_ready));

    // R2: ready stays low in the cycle after the pulse falls
    assert_tail_guard_R2: assert property (@(posedge clk) disable iff (rst)
        $fell(sync_pulse) |-> !data_ready);
endmodule

// File: tb/sync_pulse_sched_test.sv
module sync_pulse_sched_test;
    localparam int unsigned WIDTH = 12;
    localparam int unsigned BASE  = 4;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [WIDTH-1:0] cfg_width  = '0;
    logic [WIDTH-1:0] cfg_period = '0;
    logic [1:0]       band_sel   = '0;
    logic             sync_pulse, data_ready, fill_sel;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    sync_pulse_sched #(.WIDTH(WIDTH), .BASE_MIN(BASE)) uut (
        .clk(clk), .rst(rst), .cfg_width(cfg_width), .cfg_period(cfg_period),
        .band_sel(band_sel), .sync_pulse(sync_pulse), .data_ready(data_ready),
        .fill_sel(fill_sel)
    );

    // band, width, period, expected width, expected period
    localparam int NV = 7;
    localparam int VEC [NV][5] = '{
        '{0,    6,  20,    6,   20},   // R1 plain
        '{1,    3,  20,    8,   20},   // R4 floor band 1
        '{3,   10, 100,   32,  100},   // R4 floor band 3
        '{2,   16,  18,   16,   19},   // R5 period raised
        '{0,    4,   7,    4,    7},   // R5 exact boundary
        '{2,   40,  50,   40,   50},   // R1 above floor
        '{0, 4095,   0, 4092, 4095}    // R10 width cap
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Samples n cycles starting with the current one at phase ph.
    task automatic observe(input int n, input int w, input int p, input int ph,
                           output int perr, output int rerr);
        perr = 0;
        rerr = 0;
        for (int k = 0; k < n; k++) begin
            int c;
            c = (k + ph) % p;
            if (sync_pulse !== ((c >= 1) && (c <= w))) perr++;
            if (data_ready !== (c > w + 1))            rerr++;
            @(negedge clk);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int pe, re;
        @(negedge clk);
        @(negedge clk);
        // R7: outputs low while reset is held
        check(sync_pulse === 1'b0, "R7 pulse in reset", sync_pulse, 0);
        check(data_ready === 1'b0, "R7 ready in reset", data_ready, 0);
        // R8: constant fill select
        check(fill_sel === 1'b1, "R8 fill select", fill_sel, 1);

        // R1 R2 R3 R4 R5 R10 vector walk
        for (int v = 0; v < NV; v++) begin
            band_sel   = 2'(VEC[v][0]);
            cfg_width  = WIDTH'(VEC[v][1]);
            cfg_period = WIDTH'(VEC[v][2]);
            do_reset();
            observe(2 * VEC[v][4], VEC[v][3], VEC[v][4], 0, pe, re);
            check(pe == 0, $sformatf("R1/R3 vector %0d pulse mismatches", v), pe, 0);
            check(re == 0, $sformatf("R2 vector %0d ready mismatches", v), re, 0);
        end

        // R6: change all settings mid-period
        band_sel = 2'd0; cfg_width = 12'd6; cfg_period = 12'd20;
        do_reset();
        observe(3, 6, 20, 0, pe, re);
        band_sel = 2'd1; cfg_width = 12'd5; cfg_period = 12'd15;
        observe(17, 6, 20, 3, pe, re);
        check(pe == 0, "R6 old width kept", pe, 0);
        check(re == 0, "R6 old ready kept", re, 0);
        observe(30, 8, 15, 0, pe, re);
        check(pe == 0, "R6 new settings at wrap", pe, 0);
        check(re == 0, "R6 new ready at wrap", re, 0);

        // R7: reset in the middle of a pulse restarts at cycle 0
        band_sel = 2'd0; cfg_width = 12'd6; cfg_period = 12'd20;
        do_reset();
        observe(4, 6, 20, 0, pe, re);
        rst = 1'b1;
        @(negedge clk);
        check(sync_pulse === 1'b0, "R7 pulse cut by reset", sync_pulse, 0);
        check(data_ready === 1'b0, "R7 ready low in reset", data_ready, 0);
        rst = 1'b0;
        check(sync_pulse === 1'b0, "R7 guard cycle after reset", sync_pulse, 0);
        @(negedge clk);
        check(sync_pulse === 1'b1, "R7 pulse starts after guard", sync_pulse, 1);
        check(data_ready === 1'b0, "R9 ready low during pulse", data_ready, 0);
        observe(39, 6, 20, 1, pe, re);
        check(pe == 0 && re == 0, "R7 pattern after reset", pe + re, 0);
        check(fill_sel === 1'b1, "R8 fill select at end", fill_sel, 1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule